// File: doc/BRIEF.md
# Fixed-Priority Bus Arbiter with Ownership Timeout

This block decides which of four bus masters owns a shared AHB-style bus. Each master raises a request line; the arbiter returns a one-hot grant vector and a binary number naming the master whose transfer is in its address phase. Master 0 has the highest priority and master 3 the lowest. When nobody requests, the bus is parked on the default master (master 0).

Grants change only on a clock edge where the bus ready signal is high, so a transfer in progress is never cut mid-phase. To stop one master from holding the bus forever, an ownership timer counts the active (non-IDLE) transfer cycles of the current owner. Once the count reaches `MAX_HOLD`, and another master is waiting, the owner is passed over at the next ready edge. The highest-priority waiting master then wins.

Top module: `ahb_fixed_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the grant becomes `4'b0001`, `owner_id` becomes 0 and the ownership timer clears.
- R2: Exactly one bit of `grant` is high in every cycle after reset.
- R3: `grant` changes only at a clock edge where `hready` is 1. When `hready` is 0 it holds its value.
- R4: At a ready edge, the requester with the lowest index wins (bit i of `req` and `grant` belong to master i). A higher-priority request pre-empts a lower-priority owner that has not expired.
- R5: At a ready edge with `req == 0`, the grant goes to master 0.
- R6: If the owner drops its request while others request, the grant moves to the highest-priority requester at the next ready edge.
- R7: The ownership timer clears when the grant changes. At every other edge where `htrans != 2'b00` (not IDLE) it increments, saturating at `MAX_HOLD`. IDLE cycles do not count.
- R8: When the timer equals `MAX_HOLD` and some master other than the owner requests, the owner is excluded at the next ready edge. The highest-priority other requester is granted.
- R9: When the timer equals `MAX_HOLD` and only the owner requests, the owner keeps the grant.
- R10: At each ready edge, `owner_id` takes the binary number of the master that was granted before that edge. At other edges it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 4 | Bus request, one bit per master |
| hready | input | 1 | Bus ready; a high value ends the current data phase |
| htrans | input | 2 | Transfer type on the bus; 2'b00 is IDLE |
| grant | output | 4 | One-hot bus grant |
| owner_id | output | 2 | Number of the master owning the current address phase |

## Verification
`grant` responds to the inputs present at a ready edge in the same edge, one register deep. `owner_id` lags the grant by one more ready edge. The timer's effect shows only after `MAX_HOLD` counted active cycles and then one further ready edge. The bench keeps a cycle model of these registers that is updated at each rising edge from the inputs held there. It drives inputs and compares outputs at the falling edge, so each result is read one edge after the stimulus that produced it. Directed sequences cover reset, parking, pre-emption, request drop, IDLE cycles not counting, and expiry with and without waiters. These are followed by seeded random traffic.

// File: rtl/arb_pkg.sv
// Shared definitions for the bus arbiter.
// Assumes the two-bit transfer-type encoding with IDLE as 2'b00.
package arb_pkg;
    typedef enum logic [1:0] {
        XFER_IDLE   = 2'b00,
        XFER_BUSY   = 2'b01,
        XFER_NONSEQ = 2'b10,
        XFER_SEQ    = 2'b11
    } xfer_e;
endpackage

// File: rtl/arb_prio_pick.sv
// Fixed-priority picker: returns a one-hot vector with the lowest-index set bit of cand.
// Assumes index 0 carries the highest priority. Pure combinational.
module arb_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] cand,
    output logic [N-1:0] pick,
    output logic         any
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;
    assign any        = |cand;

    // Ripple a "someone above already won" flag down the priority chain.
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign pick[i]      = cand[i] & ~blocked[i];
        assign blocked[i+1] = blocked[i] | cand[i];
    end
endmodule

// File: rtl/arb_onehot_enc.sv
// One-hot to binary encoder for the grant vector.
// Assumes at most one input bit is set.
module arb_onehot_enc #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  oh,
    output logic [IW-1:0] idx
);
    // OR together the index of every set bit.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (oh[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/arb_hold_timer.sv
// Ownership timer: counts active transfer cycles of the current owner.
// Clears when the grant changes and saturates at MAX_HOLD.
// Assumes handover is signalled in the same cycle as the grant register update.
module arb_hold_timer #(
    parameter int N        = 4,
    parameter int MAX_HOLD = 8,
    localparam int CW      = $clog2(MAX_HOLD + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         handover,
    input  logic         bus_active,
    input  logic [N-1:0] grant,
    output logic         expired
);
    logic [CW-1:0] cnt;

    // Count the owner's non-IDLE cycles and restart on every change of owner.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cnt <= '0;
        else if (handover)                         cnt <= '0;
        else if (bus_active && cnt != CW'(MAX_HOLD)) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == CW'(MAX_HOLD));

    // R7: a fresh owner starts with a cleared count
    a_r7_clear_on_handover: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(grant) |-> cnt == '0);

    // R7: the count never passes the limit
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_HOLD));

    // R7: IDLE cycles without handover leave the count unchanged
    a_r7_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_active && !handover) |=> $stable(cnt));
endmodule

// File: rtl/ahb_fixed_arbiter.sv
// Fixed-priority arbiter for NUM_MASTERS bus masters with an ownership timeout.
// Master 0 has the highest priority. The default master parks the bus when idle.
// Grants move only on edges with hready high. owner_id tracks the address-phase owner.
// Assumes req is synchronous to clk. Reset is synchronous, active low.
module ahb_fixed_arbiter #(
    parameter int NUM_MASTERS    = 4,
    parameter int MAX_HOLD       = 8,
    parameter int DEFAULT_MASTER = 0,
    localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   hready,
    input  logic [1:0]             htrans,
    output logic [NUM_MASTERS-1:0] grant,
    output logic [IW-1:0]          owner_id
);
    import arb_pkg::*;

    localparam logic [NUM_MASTERS-1:0] DEF_OH = NUM_MASTERS'(1) << DEFAULT_MASTER;

    logic [NUM_MASTERS-1:0] cand_mask;
    logic [NUM_MASTERS-1:0] cand;
    logic [NUM_MASTERS-1:0] pick;
    logic                   pick_any;
    logic [NUM_MASTERS-1:0] grant_nxt;
    logic [IW-1:0]          grant_idx;
    logic                   expired;
    logic                   others_wait;
    logic                   bus_active;

    assign bus_active  = (xfer_e'(htrans) != XFER_IDLE);
    assign others_wait = |(req & ~grant);

    // Exclude an expired owner while someone else is waiting.
    always_comb begin
        cand_mask = (expired && others_wait) ? ~grant : '1;
        cand      = req & cand_mask;
    end

    arb_prio_pick #(.N(NUM_MASTERS)) u_pick (
        .cand (cand),
        .pick (pick),
        .any  (pick_any)
    );

    // Choose the next owner; hold unless the bus is ready.
    always_comb begin
        if (!hready)       grant_nxt = grant;
        else if (pick_any) grant_nxt = pick;
        else               grant_nxt = DEF_OH;
    end

    // Grant register, parked on the default master at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) grant <= DEF_OH;
        else        grant <= grant_nxt;
    end

    arb_onehot_enc #(.N(NUM_MASTERS)) u_enc (
        .oh  (grant),
        .idx (grant_idx)
    );

    // Owner number moves into the address phase on each ready edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      owner_id <= IW'(DEFAULT_MASTER);
        else if (hready) owner_id <= grant_idx;
    end

    arb_hold_timer #(.N(NUM_MASTERS), .MAX_HOLD(MAX_HOLD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .handover   (grant_nxt != grant),
        .bus_active (bus_active),
        .grant      (grant),
        .expired    (expired)
    );

    // R2: exactly one grant bit
    a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == 1);

    // R3: no handover without ready
    a_r3_hold_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> $stable(grant));

    // R5: park on the default master when nobody requests
    a_r5_park_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && req == '0) |=> grant == DEF_OH);

    // R4: top-priority requester wins at a ready edge
    a_r4_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && req[0]) |=> grant[0] || $past(grant[0]));

    // R8: expired owner with waiters is replaced
    a_r8_expiry_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && expired && others_wait) |=> grant != $past(grant));

    // R9: sole requester keeps the bus
    a_r9_sole_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && req == grant) |=> $stable(grant));

    // R10: owner number follows the prior grant on ready edges
    a_r10_id_follows: assert property (@(posedge clk) disable iff (!rst_n)
        hready |=> owner_id == $past(grant_idx));
endmodule

// File: tb/ahb_fixed_arbiter_tb.sv
// Self-checking bench: directed corner cases then seeded random traffic,
// compared every cycle with a cycle model built from the requirements.
module ahb_fixed_arbiter_tb_top;
    localparam int NM  = 4;
    localparam int MAX = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req = '0;
    logic          hready = 1'b1;
    logic [1:0]    htrans = 2'b00;
    logic [NM-1:0] grant;
    logic [1:0]    owner_id;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    ahb_fixed_arbiter #(.NUM_MASTERS(NM), .MAX_HOLD(MAX)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .hready(hready),
        .htrans(htrans), .grant(grant), .owner_id(owner_id)
    );

    // Lowest set index as one-hot (0 if none).
    function automatic logic [NM-1:0] first_oh(input logic [NM-1:0] v);
        for (int i = 0; i < NM; i++) if (v[i]) return NM'(1) << i;
        return '0;
    endfunction

    function automatic logic [1:0] oh_num(input logic [NM-1:0] v);
        for (int i = 0; i < NM; i++) if (v[i]) return 2'(i);
        return 2'd0;
    endfunction

    // Expected next grant from the requirements R3..R9.
    function automatic logic [NM-1:0] exp_next(input logic [NM-1:0] g, input logic [NM-1:0] r,
                                               input bit rdy, input int cnt);
        logic [NM-1:0] c;
        if (!rdy) return g;
        c = r;
        if (cnt == MAX && (r & ~g) != '0) c = r & ~g;
        if (c == '0) return 4'b0001;
        return first_oh(c);
    endfunction

    logic [NM-1:0] m_grant;
    logic [1:0]    m_id;
    int            m_cnt;

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        logic [NM-1:0] nx;
        if (!rst_n) begin
            m_grant <= 4'b0001; m_id <= 2'd0; m_cnt <= 0;
        end else begin
            nx = exp_next(m_grant, req, hready, m_cnt);
            if (nx != m_grant)                   m_cnt <= 0;
            else if (htrans != 2'b00 && m_cnt < MAX) m_cnt <= m_cnt + 1;
            if (hready) m_id <= oh_num(m_grant);
            m_grant <= nx;
        end
    end

    task automatic check(input string tag);
        n_checks++;
        if (grant !== m_grant || owner_id !== m_id) begin
            n_fail++;
            $display("FAIL %s: grant=%b owner_id=%0d expected grant=%b owner_id=%0d",
                     tag, grant, owner_id, m_grant, m_id);
        end
    endtask

    // Drive inputs after a falling edge, step one cycle, check at the next falling edge.
    task automatic step(input logic [NM-1:0] r, input bit rdy, input logic [1:0] ht, input string tag);
        req = r; hready = rdy; htrans = ht;
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset state");
        if (grant !== 4'b0001) begin n_fail++; $display("FAIL R1: grant=%b expected 0001", grant); end
        n_checks++;

        // R4, R10: lower master takes the parked bus, id lags one ready edge
        step(4'b0100, 1, 2'b10, "R4 lone requester");
        step(4'b0100, 1, 2'b10, "R10 id follows");
        // R3: no change without ready
        step(4'b0001, 0, 2'b11, "R3 hold not ready");
        step(4'b0001, 0, 2'b11, "R3 hold not ready 2");
        step(4'b0001, 1, 2'b11, "R4 pre-emption by master 0");
        // R5: parking
        step(4'b0100, 1, 2'b10, "R4 master 2");
        step(4'b0000, 1, 2'b00, "R5 park on master 0");
        // R6: owner drops request
        step(4'b1000, 1, 2'b10, "R6 setup owner 3");
        step(4'b0100, 1, 2'b10, "R6 owner dropped");
        // R7: IDLE cycles do not age the owner
        step(4'b0011, 1, 2'b10, "R7 setup owner 0");
        for (int i = 0; i < 2 * MAX; i++) step(4'b0011, 1, 2'b00, "R7 idle no count");
        // R8: active cycles expire owner 0 with master 1 waiting
        for (int i = 0; i < MAX + 2; i++) step(4'b0011, 1, 2'b11, "R8 expiry handover");
        // R9: sole requester never loses the bus
        for (int i = 0; i < 3 * MAX; i++) step(4'b0100, 1, 2'b11, "R9 sole requester keeps");
        // R8 with late waiter and hready low at expiry
        for (int i = 0; i < 3; i++) step(4'b0110, 0, 2'b11, "R3 R8 expiry waits for ready");
        step(4'b0110, 1, 2'b11, "R8 expired owner replaced");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [NM-1:0] r;
            r = NM'($urandom);
            if ($urandom_range(0, 3) == 0) r = '0;
            step(r, ($urandom_range(0, 3) != 0), 2'($urandom), "R2 R4 R7 R8 R10 random");
            n_checks++;
            if ($countones(grant) != 1) begin
                n_fail++;
                $display("FAIL R2: grant=%b expected one-hot", grant);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule